// File: doc/BRIEF.md
# Dual-Channel Reloadable Timer

This peripheral holds two independent 32-bit counters that software reaches through a small register bus. The bus has a select, a write strobe, a byte address and 32-bit data, and it completes an access in a single cycle. Each channel has three registers: a control/status word, a load value and a live count. Software starts a channel in a fixed order. It writes the load value, parks the counter on it with the load bit, then sets the run bits and clears the load bit in a second control write.

A channel counts one step per clock in either direction. At its terminal count it raises a sticky interrupt flag. If auto-reload is set, the counter then restarts from the load value. If auto-reload is clear, the counter stops. The usual arrangement uses the two channels differently. One runs down with auto-reload to give a periodic interrupt tick. The other runs up from zero with auto-reload and no interrupt, as a free-running time base. Writing back the control word that was just read acknowledges an interrupt and leaves the other settings unchanged.

The capture, PWM, external-signal and all-channel enable bits are only stored. They read back as written but have no other effect.

Top module: `twin_timer`

## Requirements
- R1: Channel n owns byte offsets 16n+0 (control), 16n+4 (load) and 16n+8 (count). Offsets 16n+12 read as 0, and writes to them change nothing.
- R2: Control bits 0 (mode), 1 (down), 2 (generate), 3 (capture), 4 (auto-reload), 5 (load), 6 (interrupt enable), 7 (run), 9 (PWM) and 10 (all-enable) read back exactly as last written. Bits 31..11 read as 0.
- R3: Control bit 8 is the interrupt flag. The terminal count of its channel sets it. A control write with bit 8 = 1 clears it. A control write with bit 8 = 0 leaves it unchanged.
- R4: While control bit 5 is 1, the counter takes the load register value on every clock. After bit 5 is written back to 0, counting continues from that value.
- R5: While bit 7 is 1, the counter moves one step per clock. It decrements when bit 1 = 1 and increments when bit 1 = 0.
- R6: With bit 4 set, the counter takes the load value on the clock at which it would pass its terminal count. Terminal count is 0 when counting down and all ones when counting up. The flag sets on that same clock. A down count from load value L therefore has a period of L+1 clocks, so load value 1 gives 2 clocks.
- R7: With bit 4 clear, the counter stays at its terminal value and sets the flag once. It stays there until the load bit is set or the run bit is cleared.
- R8: Interrupt output n is high exactly when channel n has both bit 6 and bit 8 set.
- R9: Writes to a count register are ignored.
- R10: A synchronous active-high reset clears every register to 0 and drives both interrupt outputs low.
- R11: Activity on one channel leaves the other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | Access strobe for this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (5) | Byte address; bits 1..0 ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of a read |
| irq | output | NUM_CH (2) | Per-channel interrupt request |

## Verification
The checker assumes that bus inputs are free of X after reset, that each access names one word, and that reset is held for at least one full clock before release. Its per-cycle step and reload properties are conditioned on the channel's own stop flag, so they remain valid after any sequence of control writes. The bench keeps to these assumptions. It drives every bus field at the falling edge, issues exactly one access per cycle, and starts every run from a cleared control word followed by a load-bit write. This makes each run begin from a known count, so the number of clocks it lasts can be counted exactly.

// File: rtl/twin_timer_pkg.sv
`timescale 1ns/1ps
package twin_timer_pkg;

  parameter int unsigned TMR_W = 32;

  // Control word; declaration order gives the bit positions 10 down to 0.
  typedef struct packed {
    logic allEn;       // 10
    logic pwmEn;       // 9
    logic irqFlag;     // 8
    logic runEn;       // 7
    logic irqEn;       // 6
    logic holdLoad;    // 5
    logic autoReload;  // 4
    logic captEn;      // 3
    logic genEn;       // 2
    logic countDown;   // 1
    logic modeSel;     // 0
  } ctlReg_t;

  localparam int unsigned CTL_W    = $bits(ctlReg_t);
  localparam int unsigned FLAG_BIT = 8;

  typedef enum logic [1:0] {
    REG_CTL   = 2'd0,
    REG_LOAD  = 2'd1,
    REG_COUNT = 2'd2,
    REG_NONE  = 2'd3
  } regSel_e;

  // Strobes from the register block to one counting datapath.
  typedef struct packed {
    logic [TMR_W-1:0] reloadVal;
    logic             hold;
    logic             run;
    logic             down;
    logic             wrap;
  } chanCmd_t;

endpackage

// File: rtl/twin_timer_chan.sv
`timescale 1ns/1ps
module twin_timer_chan
  import twin_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  chanCmd_t         cmd,
  output logic [TMR_W-1:0] count,
  output logic             expired,
  output logic             termHit
);

  localparam logic [TMR_W-1:0] CNT_MAX = {TMR_W{1'b1}};
  localparam logic [TMR_W-1:0] CNT_ONE = TMR_W'(1);

  logic             atEnd;
  logic [TMR_W-1:0] stepVal;

  assign atEnd   = cmd.down ? (count == '0) : (count == CNT_MAX);
  assign termHit = cmd.run && !cmd.hold && !expired && atEnd;
  assign stepVal = cmd.down ? (count - CNT_ONE) : (count + CNT_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      expired <= 1'b0;
    end else begin
      if (cmd.hold)
        count <= cmd.reloadVal;
      else if (termHit)
        count <= cmd.wrap ? cmd.reloadVal : count;
      else if (cmd.run && !expired)
        count <= stepVal;

      if (cmd.hold || !cmd.run)
        expired <= 1'b0;
      else if (termHit && !cmd.wrap)
        expired <= 1'b1;
    end
  end

endmodule

// File: rtl/twin_timer_regs.sv
`timescale 1ns/1ps
module twin_timer_regs
  import twin_timer_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         busSel,
  input  logic                         busWr,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [TMR_W-1:0]             busWdata,
  output logic [TMR_W-1:0]             busRdata,
  input  logic [NUM_CH-1:0]            termHit,
  input  logic [NUM_CH-1:0][TMR_W-1:0] cntQ,
  output chanCmd_t [NUM_CH-1:0]        cmd,
  output ctlReg_t [NUM_CH-1:0]         ctlQ,
  output logic [NUM_CH-1:0][TMR_W-1:0] loadQ
);

  localparam int unsigned CH_W = ADDR_W - 4;

  logic [CH_W-1:0] chIdx;
  regSel_e         regSel;
  logic [1:0]      unusedByteLane;

  assign chIdx          = busAddr[ADDR_W-1:4];
  assign regSel         = regSel_e'(busAddr[3:2]);
  assign unusedByteLane = busAddr[1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             chHit;
    logic             ctlWr;
    logic             loadWr;
    ctlReg_t          ctlR;
    ctlReg_t          ctlNext;
    logic [TMR_W-1:0] loadR;

    assign chHit  = busSel && busWr && (chIdx == CH_W'(c));
    assign ctlWr  = chHit && (regSel == REG_CTL);
    assign loadWr = chHit && (regSel == REG_LOAD);

    // Terminal count wins over a simultaneous acknowledge.
    always_comb begin
      ctlNext = ctlR;
      if (ctlWr)
        ctlNext = ctlReg_t'(busWdata[CTL_W-1:0]);
      ctlNext.irqFlag = termHit[c] ||
                        (ctlR.irqFlag && !(ctlWr && busWdata[FLAG_BIT]));
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ctlR  <= '0;
        loadR <= '0;
      end else begin
        ctlR <= ctlNext;
        if (loadWr)
          loadR <= busWdata;
      end
    end

    assign ctlQ[c]  = ctlR;
    assign loadQ[c] = loadR;
    assign cmd[c]   = '{reloadVal: loadR,
                        hold:      ctlR.holdLoad,
                        run:       ctlR.runEn,
                        down:      ctlR.countDown,
                        wrap:      ctlR.autoReload};
  end

  always_comb begin
    busRdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (busSel && (chIdx == CH_W'(c))) begin
        case (regSel)
          REG_CTL:   busRdata = TMR_W'(ctlQ[c]);
          REG_LOAD:  busRdata = loadQ[c];
          REG_COUNT: busRdata = cntQ[c];
          default:   busRdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/twin_timer.sv
`timescale 1ns/1ps
module twin_timer
  import twin_timer_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [TMR_W-1:0]  busWdata,
  output logic [TMR_W-1:0]  busRdata,
  output logic [NUM_CH-1:0] irq
);

  chanCmd_t [NUM_CH-1:0]        cmd;
  ctlReg_t [NUM_CH-1:0]         ctlQ;
  logic [NUM_CH-1:0][TMR_W-1:0] loadQ;
  logic [NUM_CH-1:0][TMR_W-1:0] cntQ;
  logic [NUM_CH-1:0]            expQ;
  logic [NUM_CH-1:0]            termHit;

  twin_timer_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .termHit  (termHit),
    .cntQ     (cntQ),
    .cmd      (cmd),
    .ctlQ     (ctlQ),
    .loadQ    (loadQ)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dp
    twin_timer_chan u_chan (
      .clk     (clk),
      .rst     (rst),
      .cmd     (cmd[c]),
      .count   (cntQ[c]),
      .expired (expQ[c]),
      .termHit (termHit[c])
    );
    assign irq[c] = ctlQ[c].irqEn && ctlQ[c].irqFlag;
  end

endmodule

// File: rtl/twin_timer_chk.sv
`timescale 1ns/1ps
module twin_timer_chk
  import twin_timer_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 5
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         busSel,
  input logic                         busWr,
  input logic [ADDR_W-1:0]            busAddr,
  input logic [TMR_W-1:0]             busWdata,
  input logic [NUM_CH-1:0]            irq,
  input ctlReg_t [NUM_CH-1:0]         ctlQ,
  input logic [NUM_CH-1:0][TMR_W-1:0] loadQ,
  input logic [NUM_CH-1:0][TMR_W-1:0] cntQ,
  input logic [NUM_CH-1:0]            expQ
);

  localparam int unsigned CH_W = ADDR_W - 4;
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  logic unusedWdata;
  assign unusedWdata = ^{busWdata, busAddr[1:0]};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    logic ctlWr;
    logic cntWr;
    logic stepOk;
    assign ctlWr  = busSel && busWr && (busAddr[ADDR_W-1:4] == CH_W'(c)) && (busAddr[3:2] == 2'd0);
    assign cntWr  = busSel && busWr && (busAddr[ADDR_W-1:4] == CH_W'(c)) && (busAddr[3:2] == 2'd2);
    assign stepOk = ctlQ[c].runEn && !ctlQ[c].holdLoad && !expQ[c];

    // R3: flag stays set unless acknowledged
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      ctlQ[c].irqFlag && !(ctlWr && busWdata[FLAG_BIT]) |=> ctlQ[c].irqFlag);

    // R3: flag only rises while the channel is counting
    a_r3_flag_source: assert property (@(posedge clk) disable iff (rst)
      $rose(ctlQ[c].irqFlag) |-> $past(ctlQ[c].runEn));

    // R4: load bit forces the load value
    a_r4_hold_load: assert property (@(posedge clk) disable iff (rst)
      ctlQ[c].holdLoad |=> cntQ[c] == $past(loadQ[c]));

    // R5: one step down per clock
    a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
      stepOk && ctlQ[c].countDown && cntQ[c] != '0 |=> cntQ[c] == $past(cntQ[c]) - ONE);

    // R5: one step up per clock
    a_r5_step_up: assert property (@(posedge clk) disable iff (rst)
      stepOk && !ctlQ[c].countDown && cntQ[c] != '1 |=> cntQ[c] == $past(cntQ[c]) + ONE);

    // R6: terminal count reloads and flags together
    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
      stepOk && ctlQ[c].autoReload && ctlQ[c].countDown && cntQ[c] == '0
      |=> cntQ[c] == $past(loadQ[c]) && ctlQ[c].irqFlag);

    // R7: without reload the counter rests at zero
    a_r7_stop_at_end: assert property (@(posedge clk) disable iff (rst)
      ctlQ[c].runEn && !ctlQ[c].holdLoad && !ctlQ[c].autoReload &&
      ctlQ[c].countDown && cntQ[c] == '0 |=> cntQ[c] == '0);

    // R8: no request while interrupts are disabled
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
      !ctlQ[c].irqEn |-> !irq[c]);

    // R9: count register writes do not land
    a_r9_count_write_ignored: assert property (@(posedge clk) disable iff (rst)
      cntWr && !ctlQ[c].runEn && !ctlQ[c].holdLoad |=> $stable(cntQ[c]));
  end

endmodule

bind twin_timer twin_timer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .irq      (irq),
  .ctlQ     (ctlQ),
  .loadQ    (loadQ),
  .cntQ     (cntQ),
  .expQ     (expQ)
);

// File: tb/twin_timer_test.sv
`timescale 1ns/1ps
module twin_timer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  irq;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  twin_timer uut (
    .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  typedef struct packed {
    logic        chan;
    logic [15:0] ctl;
    logic [31:0] load;
    logic [15:0] steps;
    logic [31:0] expCnt;
    logic        expFlag;
  } vecT;

  localparam int NVEC = 10;
  localparam vecT VECS [NVEC] = '{
    '{1'b0, 16'h082, 32'd10,         16'd4,  32'd6,          1'b0},
    '{1'b0, 16'h080, 32'd5,          16'd7,  32'd12,         1'b0},
    '{1'b0, 16'h0C2, 32'd3,          16'd10, 32'd0,          1'b1},
    '{1'b0, 16'h092, 32'd3,          16'd6,  32'd1,          1'b1},
    '{1'b0, 16'h0D2, 32'd1,          16'd5,  32'd0,          1'b1},
    '{1'b0, 16'h090, 32'hFFFFFFFD,   16'd5,  32'hFFFFFFFF,   1'b1},
    '{1'b0, 16'h092, 32'd0,          16'd3,  32'd0,          1'b1},
    '{1'b0, 16'h0C0, 32'hFFFFFFFE,   16'd6,  32'hFFFFFFFF,   1'b1},
    '{1'b1, 16'h082, 32'd100,        16'd30, 32'd70,         1'b0},
    '{1'b1, 16'h0D0, 32'd0,          16'd20, 32'd20,         1'b0}
  };

  function automatic string tagOf(int i);
    case (i)
      0, 1:       return "R5";
      2, 7:       return "R7";
      8:          return "R11";
      default:    return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), v);
      chk("R10", $sformatf("reset read %0h", a), v, 32'h0);
    end
    chk("R10", "reset irq", {30'b0, irq}, 32'h0);

    // Vector table: each row runs one channel for an exact number of clocks.
    for (int i = 0; i < NVEC; i++) begin
      vecT        r;
      logic [4:0] base;
      r = VECS[i];
      base = {r.chan, 4'h0};
      wr(base, 32'h100);
      wr(base + 5'd4, r.load);
      wr(base, 32'h020);
      wr(base, {16'h0, r.ctl});
      idle(int'(r.steps) - 1);
      wr(base, {16'h0, r.ctl & 16'hFF7F});
      rd(base + 5'd8, v);
      chk(tagOf(i), $sformatf("row %0d count", i), v, r.expCnt);
      rd(base, v);
      chk("R3", $sformatf("row %0d flag", i), {31'b0, v[8]}, {31'b0, r.expFlag});
      chk("R8", $sformatf("row %0d irq", i), {31'b0, irq[r.chan]},
          {31'b0, r.expFlag & r.ctl[6]});
    end

    // R11: channel 0 untouched by channel 1 runs
    rd(5'h08, v);
    chk("R11", "ch0 count after ch1 runs", v, 32'hFFFFFFFF);

    // R3: write 0 to flag keeps it, write-back acknowledges
    rd(5'h00, v);
    chk("R3", "ch0 ctl before ack", v, 32'h140);
    wr(5'h00, 32'h040);
    rd(5'h00, v);
    chk("R3", "write 0 keeps flag", v, 32'h140);
    chk("R8", "irq pending", {31'b0, irq[0]}, 32'h1);
    wr(5'h00, 32'h140);
    rd(5'h00, v);
    chk("R3", "write-back ack", v, 32'h040);
    chk("R8", "irq after ack", {31'b0, irq[0]}, 32'h0);

    // R2: stored control bits
    wr(5'h10, 32'hFFFFFEFF);
    rd(5'h10, v);
    chk("R2", "ch1 ctl readback", v, 32'h6FF);
    wr(5'h10, 32'h100);

    // R4: hold, update while holding, resume
    wr(5'h04, 32'd50);
    wr(5'h00, 32'h0A2);
    idle(3);
    rd(5'h08, v);
    chk("R4", "held at load", v, 32'd50);
    wr(5'h04, 32'd77);
    idle(1);
    rd(5'h08, v);
    chk("R4", "follows new load", v, 32'd77);
    wr(5'h00, 32'h082);
    idle(4);
    wr(5'h00, 32'h002);
    rd(5'h08, v);
    chk("R4", "resume from load", v, 32'd72);

    // R9: count write ignored
    wr(5'h08, 32'h1234);
    rd(5'h08, v);
    chk("R9", "count after write", v, 32'd72);

    // R1: map and unmapped offsets
    wr(5'h14, 32'hABCD);
    wr(5'h0C, 32'hFFFF);
    wr(5'h1C, 32'hFFFF);
    rd(5'h14, v);
    chk("R1", "ch1 load", v, 32'hABCD);
    rd(5'h04, v);
    chk("R1", "ch0 load", v, 32'd77);
    rd(5'h0C, v);
    chk("R1", "ch0 hole", v, 32'h0);
    rd(5'h1C, v);
    chk("R1", "ch1 hole", v, 32'h0);

    // R10: reset during activity
    wr(5'h00, 32'h1D2);
    idle(5);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    rd(5'h08, v);
    chk("R10", "count after reset", v, 32'h0);
    rd(5'h00, v);
    chk("R10", "ctl after reset", v, 32'h0);
    rd(5'h04, v);
    chk("R10", "load after reset", v, 32'h0);
    chk("R10", "irq after reset", {30'b0, irq}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule